// File: doc/BRIEF.md
# Chip-Mode Change Request Validator

This block sits between software's mode-control register write and the chip's mode sequencer. Every write that names a target chip mode is checked here. A request that passes every check, and that was written with the two-step unlock, is handed on as a one-cycle accept strobe carrying the target mode. A request that fails is rejected. Exactly one cause bit is recorded for it, chosen by a fixed priority, and a sticky interrupt pending bit is raised.

The block tracks the current mode, the pending target and a transition-busy flag. The current mode is the parent mode while a transition runs, because the current mode only changes when the sequencer signals completion. A per-mode enable mask and a low-power-exit failure flag come in as inputs. Cause bits and the pending bit are cleared by writing ones to them.

Mode codes: RESET=0, SAFE=2, RUN0..RUN3=4..7, HALT0=8, STOP0=10. Every other 4-bit code names no mode.

Top module: `mode_req_guard`

## Requirements
- R1: A write is keyed only when it directly follows a write with the same mode and key 16'h5AF0, and itself carries key 16'hA50F. A keyed write with no failing check raises `acc_o` for one cycle after the write edge, with `acc_mode_o` holding the requested mode.
- R2: A write that is not keyed is never accepted. It never records cause bits 1 or 0, and it leaves the current mode and the busy flag unchanged.
- R3: While the current mode is SAFE, any write whose target is neither SAFE nor RESET records cause bit 4 (safe error), whether keyed or not.
- R4: Any write whose target code names no mode records cause bit 3 (no such mode), whether keyed or not.
- R5: Any write whose target other than SAFE or RESET has a 0 at its code's position in `mode_en_i` records cause bit 2 (disabled mode), whether keyed or not.
- R6: A keyed write records cause bit 1 (illegal request) in two cases. The first is a target that is not a legal successor: from a RUN mode the legal targets are RUN0..3, HALT0 and STOP0, and from RESET, HALT0 or STOP0 they are RUN0..3. The second is a target other than SAFE or RESET while `lp_fail_i` is 1.
- R7: While busy, a keyed write whose target is neither SAFE, RESET, the current (parent) mode nor the pending target records cause bit 0 (in transition). A request for the parent mode (abort) or for the pending target is accepted, and it is not checked against the successor table.
- R8: Targets SAFE and RESET never record a cause, whether busy or not and whatever `lp_fail_i` is. When keyed, they are accepted.
- R9: When several causes hold for one write, only the highest is recorded, in the order bit 4, 3, 2, 1, 0.
- R10: An accepted request sets `busy_o` and stores the target. A `done_i` pulse while busy copies the target into `cur_mode_o` and clears `busy_o`. A `done_i` pulse while idle has no effect.
- R11: Any recorded cause sets `pend_o`. Writing `clr_bits` with `clr_en` clears each cause bit whose bit in `clr_bits[4:0]` is 1, and clears `pend_o` when `clr_bits[5]` is 1. Status that is not cleared stays set.
- R12: `irq_o` is 1 exactly when `pend_o` and `irq_mask_i` are both 1.
- R13: After reset the current mode is RUN0, and the busy flag, the key state, the causes, the pending bit and `acc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode-control write strobe |
| wr_mode | input | 4 | Requested target mode code |
| wr_key | input | 16 | Key half-word of the write |
| clr_en | input | 1 | Status clear strobe |
| clr_bits | input | 6 | Write-one-to-clear: [5] pending, [4:0] causes |
| mode_en_i | input | 16 | Per-mode enable, indexed by mode code |
| lp_fail_i | input | 1 | Low-power exit did not reach its configuration |
| done_i | input | 1 | Transition-complete pulse |
| irq_mask_i | input | 1 | Interrupt enable |
| acc_o | output | 1 | Accepted-request strobe |
| acc_mode_o | output | 4 | Target of the last accepted request |
| cur_mode_o | output | 4 | Current (parent) mode |
| busy_o | output | 1 | Transition in progress |
| cause_o | output | 5 | Sticky invalid-request causes |
| pend_o | output | 1 | Sticky interrupt pending |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench first drives overlapping causes. These are a missing mode code while in SAFE, a disabled code that is also missing, and an illegal successor while busy. A priority encoder built wrong would record two bits, or the lower bit. It then tries broken key sequences, with a wrong key, a changed mode between the halves, or a lone second half. A design that latched the key loosely would accept one of them. Abort-to-parent and repeat-target requests during a transition, and SAFE/RESET requested while `lp_fail_i` is set, would be flagged as invalid by a design that skipped the bypass paths. Partial write-one-to-clear shows whether pending and causes are cleared independently.

// File: rtl/mode_req_guard.sv
module mode_req_guard #(
  parameter logic [15:0] UNLOCK = 16'h5AF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_mode,
  input  logic [15:0] wr_key,
  input  logic        clr_en,
  input  logic [5:0]  clr_bits,
  input  logic [15:0] mode_en_i,
  input  logic        lp_fail_i,
  input  logic        done_i,
  input  logic        irq_mask_i,
  output logic        acc_o,
  output logic [3:0]  acc_mode_o,
  output logic [3:0]  cur_mode_o,
  output logic        busy_o,
  output logic [4:0]  cause_o,
  output logic        pend_o,
  output logic        irq_o
);
  localparam logic [3:0] M_RESET = 4'd0, M_SAFE = 4'd2, M_RUN0 = 4'd4,
                         M_HALT = 4'd8, M_STOP = 4'd10;

  function automatic logic is_run(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic exists(input logic [3:0] m);
    return m == M_RESET || m == M_SAFE || is_run(m) || m == M_HALT || m == M_STOP;
  endfunction

  function automatic logic legal(input logic [3:0] c, input logic [3:0] t);
    if (is_run(c))                                  return is_run(t) || t == M_HALT || t == M_STOP;
    if (c == M_RESET || c == M_HALT || c == M_STOP) return is_run(t);
    return 1'b0;
  endfunction

  logic       armed;
  logic [3:0] arm_mode, tgt;
  logic [4:0] raw, hit;

  wire keyed     = wr_en && armed && wr_key == ~UNLOCK && wr_mode == arm_mode;
  wire always_ok = wr_mode == M_RESET || wr_mode == M_SAFE;
  wire bypass    = busy_o && (wr_mode == cur_mode_o || wr_mode == tgt);

  assign raw[4] = !always_ok && cur_mode_o == M_SAFE;
  assign raw[3] = !exists(wr_mode);
  assign raw[2] = !always_ok && !mode_en_i[wr_mode];
  assign raw[1] = keyed && !always_ok && (lp_fail_i || (!bypass && !legal(cur_mode_o, wr_mode)));
  assign raw[0] = keyed && !always_ok && busy_o && !bypass;

  always_comb begin
    hit = '0;
    if (wr_en) begin
      if      (raw[4]) hit[4] = 1'b1;
      else if (raw[3]) hit[3] = 1'b1;
      else if (raw[2]) hit[2] = 1'b1;
      else if (raw[1]) hit[1] = 1'b1;
      else if (raw[0]) hit[0] = 1'b1;
    end
  end

  wire accept = keyed && raw == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      arm_mode   <= '0;
      acc_o      <= 1'b0;
      acc_mode_o <= M_RUN0;
      cur_mode_o <= M_RUN0;
      tgt        <= M_RUN0;
      busy_o     <= 1'b0;
      cause_o    <= '0;
      pend_o     <= 1'b0;
    end else begin
      if (wr_en) begin
        armed    <= wr_key == UNLOCK;
        arm_mode <= wr_mode;
      end
      acc_o <= accept;
      if (done_i && busy_o) begin
        cur_mode_o <= tgt;
        busy_o     <= 1'b0;
      end
      if (accept) begin
        acc_mode_o <= wr_mode;
        tgt        <= wr_mode;
        busy_o     <= 1'b1;
      end
      cause_o <= (cause_o & ~({5{clr_en}} & clr_bits[4:0])) | hit;
      pend_o  <= (pend_o & ~(clr_en & clr_bits[5])) | (|hit);
    end
  end

  assign irq_o = pend_o & irq_mask_i;
endmodule

// File: rtl/mode_req_guard_chk.sv
module mode_req_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       done_i,
  input logic       acc_o,
  input logic [3:0] acc_mode_o,
  input logic [3:0] cur_mode_o,
  input logic       busy_o,
  input logic [4:0] cause_o,
  input logic       pend_o,
  input logic       irq_o
);
  // R10
  acc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_o |-> busy_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_o && !wr_en) |=> !busy_o);

  // R2
  acc_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_o |-> $past(wr_en));

  // R9
  one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_o & ~$past(cause_o)));

  // R11
  cause_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause_o & ~$past(cause_o))) |-> pend_o);

  // R12
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> pend_o);

  // R3
  safe_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_mode_o) == 4'd2 && acc_o) |-> (acc_mode_o == 4'd0 || acc_mode_o == 4'd2));
endmodule

bind mode_req_guard mode_req_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .done_i(done_i), .acc_o(acc_o),
  .acc_mode_o(acc_mode_o), .cur_mode_o(cur_mode_o), .busy_o(busy_o),
  .cause_o(cause_o), .pend_o(pend_o), .irq_o(irq_o)
);

// File: tb/mode_req_guard_bench.sv
`timescale 1ns/1ps
module mode_req_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, clr_en = 1'b0, lp_fail_i = 1'b0, done_i = 1'b0, irq_mask_i = 1'b0;
  logic [3:0]  wr_mode = '0;
  logic [15:0] wr_key = '0, mode_en_i = 16'hFFFF;
  logic [5:0]  clr_bits = '0;
  logic        acc_o, busy_o, pend_o, irq_o;
  logic [3:0]  acc_mode_o, cur_mode_o;
  logic [4:0]  cause_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [10:0] expq[$];
  string       tagq[$];
  logic        due = 1'b0;

  always #10 clk = ~clk;

  mode_req_guard u_mode_req_guard (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each write's result one edge later
  always @(posedge clk) due <= wr_en;
  always @(negedge clk) begin
    if (due && expq.size() > 0) begin
      logic [10:0] e, a;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      a = {acc_o, e[10] ? acc_mode_o : e[9:6], cause_o, pend_o};
      chk(t, {21'd0, a}, {21'd0, e});
    end
  end

  task automatic wr(input logic [3:0] m, input logic [15:0] k, input logic ea,
                    input logic [4:0] ec, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m; wr_key = k;
    expq.push_back({ea, m, ec, |ec});
    tagq.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kw(input logic [3:0] m, input logic ea, input logic [4:0] c1,
                    input logic [4:0] c2, input string tag);
    wr(m, 16'h5AF0, 1'b0, c1, tag);
    wr(m, 16'hA50F, ea, c2, tag);
  endtask

  task automatic clr(input logic [5:0] b);
    @(negedge clk);
    clr_en = 1'b1; clr_bits = b;
    @(negedge clk);
    clr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 cur", cur_mode_o, 4);
    chk("R13 busy", busy_o, 0);
    chk("R13 cause", cause_o, 0);
    chk("R13 pend/irq/acc", {pend_o, irq_o, acc_o}, 0);

    kw(4'd5, 1, 0, 0, "R1 keyed RUN0->RUN1");
    chk("R10 busy set", busy_o, 1);
    chk("R10 cur held", cur_mode_o, 4);

    kw(4'd8, 0, 0, 5'b00001, "R7 new request in transition");
    chk("R12 masked", irq_o, 0);
    irq_mask_i = 1'b1;
    @(negedge clk);
    chk("R12 unmasked", irq_o, 1);
    clr(6'h3F);
    chk("R11 cleared", {cause_o, pend_o, irq_o}, 0);
    irq_mask_i = 1'b0;

    kw(4'd4, 1, 0, 0, "R7 abort to parent");
    kw(4'd4, 1, 0, 0, "R7 repeat pending target");
    done_pulse();
    chk("R10 done cur", cur_mode_o, 4);
    chk("R10 done busy", busy_o, 0);

    kw(4'd5, 1, 0, 0, "R1 keyed RUN1");
    kw(4'd5, 1, 0, 0, "R7 self during transition");
    done_pulse();
    chk("R10 cur RUN1", cur_mode_o, 5);

    wr(4'd7, 16'h1234, 0, 0, "R2 bad key");
    wr(4'd6, 16'h5AF0, 0, 0, "R2 first half");
    wr(4'd7, 16'hA50F, 0, 0, "R2 mode changed");
    wr(4'd6, 16'hA50F, 0, 0, "R2 lone second half");
    chk("R2 state kept", {busy_o, cur_mode_o}, {1'b0, 4'd5});

    wr(4'd3, 16'h0, 0, 5'b01000, "R4 no such mode");
    clr(6'h3F);

    mode_en_i[6] = 1'b0; mode_en_i[9] = 1'b0;
    wr(4'd6, 16'h0, 0, 5'b00100, "R5 disabled");
    clr(6'h3F);
    wr(4'd9, 16'h0, 0, 5'b01000, "R9 missing beats disabled");
    clr(6'h3F);
    kw(4'd6, 0, 5'b00100, 5'b00100, "R5 keyed disabled");
    clr(6'h3F);
    mode_en_i = 16'hFFFF;

    kw(4'd10, 1, 0, 0, "R6 RUN1->STOP0 legal");
    done_pulse();
    chk("R10 cur STOP0", cur_mode_o, 10);
    kw(4'd8, 0, 0, 5'b00010, "R6 STOP0->HALT0 illegal");
    clr(6'h3F);
    kw(4'd4, 1, 0, 0, "R6 STOP0->RUN0 legal");
    kw(4'd8, 0, 0, 5'b00010, "R9 illegal beats in-transition");
    clr(6'h3F);
    done_pulse();
    chk("R10 cur RUN0", cur_mode_o, 4);

    lp_fail_i = 1'b1;
    kw(4'd5, 0, 0, 5'b00010, "R6 low-power exit failed");
    clr(6'h3F);
    kw(4'd2, 1, 0, 0, "R8 SAFE after failure");
    done_pulse();
    lp_fail_i = 1'b0;
    chk("R10 cur SAFE", cur_mode_o, 2);

    wr(4'd5, 16'h0, 0, 5'b10000, "R3 leave SAFE");
    clr(6'h3F);
    wr(4'd3, 16'h0, 0, 5'b10000, "R9 safe beats missing");
    clr(6'h3F);
    kw(4'd6, 0, 5'b10000, 5'b10000, "R3 keyed from SAFE");
    clr(6'h3F);
    kw(4'd0, 1, 0, 0, "R8 RESET from SAFE");
    done_pulse();
    chk("R10 cur RESET", cur_mode_o, 0);

    kw(4'd4, 1, 0, 0, "R6 RESET->RUN0");
    kw(4'd2, 1, 0, 0, "R8 SAFE while busy");
    done_pulse();
    chk("R10 cur SAFE again", cur_mode_o, 2);
    done_pulse();
    chk("R10 idle done", {busy_o, cur_mode_o}, {1'b0, 4'd2});

    wr(4'd5, 16'h0, 0, 5'b10000, "R3 set for clear");
    clr(6'b010000);
    chk("R11 cause only", {cause_o, pend_o}, {5'b0, 1'b1});
    clr(6'b100000);
    chk("R11 pend only", pend_o, 0);

    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule